// File: doc/BRIEF.md
# Overvoltage Fault Detector with Adaptive Blanking

This block watches the comparator that checks the auxiliary-winding voltage. It decides, once per switching cycle, whether the converter output has gone over its limit. Every falling edge of the gate drive opens a window. The window first blanks out the ringing that follows turn-off, then samples the comparator for a short scan period. A comparator assertion inside the scan period is an overvoltage event. An event holds off the gate drive for the rest of that window.

Events feed a saturating up/down accumulator. An event pushes it up by one, and a cycle without an event pulls it down by one. A fault is declared once the accumulator reaches a programmable level, so isolated noise hits never trip the protection. The blanking time is set in one of two ways. It can be a fixed value chosen by a 3-bit code, or it can follow the measured gate-low time of the previous cycle minus a constant offset. A declared fault is either cleared by a restart strobe, or held until reset, according to the latch-mode input sampled when the fault is declared. All times are counted in clock cycles. The defaults assume a 100 MHz clock.

Top module: `ovp_guard`

## Requirements
- R1: While `ovp_off_i` is 1, monitoring is disabled. No comparator activity asserts `gate_block_o`, no new fault is declared, and the accumulator is held at zero. Monitoring runs while the input is 0.
- R2: A window opens at the clock edge where `gate_i` is first sampled low after being high; call this edge 0. With `blank_adapt_i` = 0, the blanking length is L = BLANK_BASE_CYC + BLANK_STEP_CYC × `blank_code_i` cycles. At the defaults this gives 1 µs plus 0.5 µs per code step.
- R3: With `blank_adapt_i` = 1, L equals the number of clock edges at which `gate_i` was sampled low during the previous switching cycle, minus ADAPT_OFFSET_CYC. L is clamped to 0 when that difference is not positive.
- R4: After reset, until one full low period has been measured from a falling edge to the next rising edge, the fixed length of R2 is used even when `blank_adapt_i` = 1.
- R5: The comparator is sampled at edges L+1 through L+SCAN_CYC, counted from edge 0. A high sample there is an event. `gate_block_o` rises immediately after the edge that sampled the event. Comparator samples outside that range are ignored.
- R6: The accumulator is updated exactly once per switching cycle, at the end of the scan period or at the rising edge of `gate_i` if that comes first. The update is +1 if the cycle had an event and −1 otherwise.
- R7: The accumulator saturates at zero and at its all-ones value.
- R8: A fault is declared when the updated accumulator is greater than or equal to `trip_level_i`. While the fault holds, `fault_o` and `gate_block_o` are both 1.
- R9: A fault declared with `latch_mode_i` = 0 is cleared, together with the accumulator, by a one-cycle pulse on `restart_i`.
- R10: A fault declared with `latch_mode_i` = 1 ignores `restart_i` and is cleared only by `rst_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, clears all state |
| gate_i | input | 1 | Gate drive level, 1 = switch on |
| cmp_i | input | 1 | Overvoltage comparator output, 1 = above limit |
| ovp_off_i | input | 1 | 1 disables monitoring, 0 enables it |
| blank_adapt_i | input | 1 | 0 = fixed blanking, 1 = previous low time minus offset |
| blank_code_i | input | CODE_W | Fixed blanking step count |
| trip_level_i | input | THR_W | Accumulator level that declares a fault |
| latch_mode_i | input | 1 | 1 = fault held until reset, 0 = cleared by restart |
| restart_i | input | 1 | Clears an unlatched fault and the accumulator |
| gate_block_o | output | 1 | Requests the gate drive be held off |
| fault_o | output | 1 | Overvoltage fault declared |

## Verification
The bound assertions check several properties on every cycle. A disabled cycle leaves only the fault able to block the gate. A fault appears only on an accumulator update and disappears only after a restart pulse. The gate block rises only after a sampled comparator high. A window closing on an event keeps the block asserted for one more cycle. Updates never come on two edges in a row. The exact blanking boundaries in both modes, the clamp and the post-reset fallback, the count of consecutive events needed to trip each threshold, the floor at zero, and the difference between latched and unlatched clearing depend on multi-cycle histories, so only the bench scenarios can show them, by sweeping codes, previous low times and thresholds.

// File: rtl/ovp_guard_pkg.sv
package ovp_guard_pkg;

    // Phase of the per-cycle observation window
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_BLANK = 2'd1,
        PH_SCAN  = 2'd2
    } win_phase_e;

endpackage

// File: rtl/ovp_low_meter.sv
// Measures the gate-low time of each switching cycle and derives the
// blanking length for the window that starts at the next falling edge.
module ovp_low_meter #(
    parameter int PER_W     = 16,
    parameter int CODE_W    = 3,
    parameter int BASE_CYC  = 100,
    parameter int STEP_CYC  = 50,
    parameter int OFS_CYC   = 50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gate_i,
    input  logic              adapt_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              fall_o,
    output logic              rise_o,
    output logic [PER_W-1:0]  blank_len_o
);

    localparam logic [PER_W-1:0] CNT_MAX = '1;
    localparam logic [PER_W-1:0] OFS     = PER_W'(OFS_CYC);

    typedef struct packed {
        logic             gate;
        logic             armed;
        logic             pvld;
        logic [PER_W-1:0] low_cnt;
        logic [PER_W-1:0] plow;
    } meter_t;

    meter_t s_d, s_q;
    logic [PER_W-1:0] fixed_len;
    logic [PER_W-1:0] adapt_len;

    always_comb begin
        s_d       = s_q;
        s_d.gate  = gate_i;
        fall_o    = s_q.gate & ~gate_i;
        rise_o    = ~s_q.gate & gate_i;

        if (fall_o) begin
            s_d.low_cnt = PER_W'(1);
            s_d.armed   = 1'b1;
        end else if (!gate_i && s_q.low_cnt != CNT_MAX) begin
            s_d.low_cnt = s_q.low_cnt + PER_W'(1);
        end

        // A low time counts only if its falling edge was seen
        if (rise_o && s_q.armed) begin
            s_d.plow = s_q.low_cnt;
            s_d.pvld = 1'b1;
        end

        fixed_len = PER_W'(BASE_CYC + STEP_CYC * int'(code_i));
        adapt_len = (s_q.plow > OFS) ? (s_q.plow - OFS) : '0;
        blank_len_o = (adapt_i && s_q.pvld) ? adapt_len : fixed_len;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/ovp_scan_window.sv
// Blanking then scanning sequence opened by each gate falling edge.
module ovp_scan_window
    import ovp_guard_pkg::*;
#(
    parameter int PER_W    = 16,
    parameter int SCAN_CYC = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             fall_i,
    input  logic             rise_i,
    input  logic             cmp_i,
    input  logic [PER_W-1:0] blank_len_i,
    output logic             done_o,
    output logic             hit_o,
    output logic             blk_o
);

    localparam logic [PER_W-1:0] SCAN_LAST = PER_W'(SCAN_CYC - 1);

    typedef struct packed {
        win_phase_e       phase;
        logic [PER_W-1:0] cnt;
        logic             hit;
        logic             blk;
    } win_t;

    win_t s_d, s_q;
    logic now_hit;

    always_comb begin
        s_d     = s_q;
        done_o  = 1'b0;
        hit_o   = 1'b0;
        now_hit = s_q.hit | cmp_i;
        s_d.blk = 1'b0;

        if (!en_i) begin
            s_d.phase = PH_IDLE;
            s_d.hit   = 1'b0;
        end else begin
            case (s_q.phase)
                PH_IDLE: begin
                    if (fall_i) begin
                        s_d.hit = 1'b0;
                        if (blank_len_i == '0) begin
                            s_d.phase = PH_SCAN;
                            s_d.cnt   = SCAN_LAST;
                        end else begin
                            s_d.phase = PH_BLANK;
                            s_d.cnt   = blank_len_i - PER_W'(1);
                        end
                    end
                end
                PH_BLANK: begin
                    if (rise_i) begin
                        done_o    = 1'b1;
                        s_d.phase = PH_IDLE;
                    end else if (s_q.cnt == '0) begin
                        s_d.phase = PH_SCAN;
                        s_d.cnt   = SCAN_LAST;
                    end else begin
                        s_d.cnt = s_q.cnt - PER_W'(1);
                    end
                end
                PH_SCAN: begin
                    s_d.blk = now_hit;
                    s_d.hit = now_hit;
                    if (rise_i || s_q.cnt == '0) begin
                        done_o    = 1'b1;
                        hit_o     = now_hit;
                        s_d.phase = PH_IDLE;
                    end else begin
                        s_d.cnt = s_q.cnt - PER_W'(1);
                    end
                end
                default: s_d.phase = PH_IDLE;
            endcase
        end
        blk_o = s_q.blk;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{phase: PH_IDLE, cnt: '0, hit: 1'b0, blk: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/ovp_event_acc.sv
// Saturating event accumulator with threshold compare and fault hold.
module ovp_event_acc #(
    parameter int ACC_W = 3,
    parameter int THR_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             done_i,
    input  logic             hit_i,
    input  logic             restart_i,
    input  logic             latch_mode_i,
    input  logic [THR_W-1:0] thr_i,
    output logic             fault_o
);

    localparam int CMP_W = (ACC_W > THR_W) ? ACC_W : THR_W;
    localparam logic [ACC_W-1:0] ACC_MAX = '1;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             fault;
        logic             lat;
    } acc_t;

    acc_t s_d, s_q;
    logic [ACC_W-1:0] acc_nxt;

    always_comb begin
        s_d     = s_q;
        acc_nxt = s_q.acc;

        if (restart_i && s_q.fault && !s_q.lat) begin
            s_d.fault = 1'b0;
            s_d.acc   = '0;
        end else if (!en_i) begin
            s_d.acc = '0;
        end else if (done_i) begin
            if (hit_i) begin
                acc_nxt = (s_q.acc == ACC_MAX) ? ACC_MAX : s_q.acc + ACC_W'(1);
            end else begin
                acc_nxt = (s_q.acc == '0) ? '0 : s_q.acc - ACC_W'(1);
            end
            s_d.acc = acc_nxt;
            if (!s_q.fault && CMP_W'(acc_nxt) >= CMP_W'(thr_i)) begin
                s_d.fault = 1'b1;
                s_d.lat   = latch_mode_i;
            end
        end
        fault_o = s_q.fault;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/ovp_guard.sv
// Overvoltage fault detector: low-time meter, window sequencer, accumulator.
module ovp_guard #(
    parameter int PER_W            = 16,
    parameter int CODE_W           = 3,
    parameter int THR_W            = 3,
    parameter int ACC_W            = 3,
    parameter int BLANK_BASE_CYC   = 100,
    parameter int BLANK_STEP_CYC   = 50,
    parameter int ADAPT_OFFSET_CYC = 50,
    parameter int SCAN_CYC         = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gate_i,
    input  logic              cmp_i,
    input  logic              ovp_off_i,
    input  logic              blank_adapt_i,
    input  logic [CODE_W-1:0] blank_code_i,
    input  logic [THR_W-1:0]  trip_level_i,
    input  logic              latch_mode_i,
    input  logic              restart_i,
    output logic              gate_block_o,
    output logic              fault_o
);

    logic             mon_en;
    logic             gate_fall;
    logic             gate_rise;
    logic [PER_W-1:0] blank_len;
    logic             win_done;
    logic             win_hit;
    logic             win_blk;
    logic             fault;

    assign mon_en = ~ovp_off_i;

    ovp_low_meter #(
        .PER_W    (PER_W),
        .CODE_W   (CODE_W),
        .BASE_CYC (BLANK_BASE_CYC),
        .STEP_CYC (BLANK_STEP_CYC),
        .OFS_CYC  (ADAPT_OFFSET_CYC)
    ) u_meter (
        .clk         (clk),
        .rst_n       (rst_n),
        .gate_i      (gate_i),
        .adapt_i     (blank_adapt_i),
        .code_i      (blank_code_i),
        .fall_o      (gate_fall),
        .rise_o      (gate_rise),
        .blank_len_o (blank_len)
    );

    ovp_scan_window #(
        .PER_W    (PER_W),
        .SCAN_CYC (SCAN_CYC)
    ) u_window (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (mon_en),
        .fall_i      (gate_fall),
        .rise_i      (gate_rise),
        .cmp_i       (cmp_i),
        .blank_len_i (blank_len),
        .done_o      (win_done),
        .hit_o       (win_hit),
        .blk_o       (win_blk)
    );

    ovp_event_acc #(
        .ACC_W (ACC_W),
        .THR_W (THR_W)
    ) u_acc (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_i         (mon_en),
        .done_i       (win_done),
        .hit_i        (win_hit),
        .restart_i    (restart_i),
        .latch_mode_i (latch_mode_i),
        .thr_i        (trip_level_i),
        .fault_o      (fault)
    );

    assign fault_o      = fault;
    assign gate_block_o = win_blk | fault;

endmodule

// File: rtl/ovp_guard_chk.sv
// Temporal checks on the detector, attached to every ovp_guard instance.
module ovp_guard_chk (
    input logic clk,
    input logic rst_n,
    input logic ovp_off_i,
    input logic cmp_i,
    input logic restart_i,
    input logic win_done,
    input logic win_hit,
    input logic gate_block_o,
    input logic fault_o
);

    // R1
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ovp_off_i) |-> (gate_block_o == fault_o));

    // R5
    block_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(gate_block_o) && !fault_o) |-> $past(cmp_i && !ovp_off_i));

    // R5
    block_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_done && win_hit) |=> gate_block_o);

    // R6
    single_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_done |=> !win_done);

    // R8
    fault_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_o) |-> $past(win_done));

    // R9
    fault_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault_o) |-> $past(restart_i));

endmodule

bind ovp_guard ovp_guard_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ovp_off_i    (ovp_off_i),
    .cmp_i        (cmp_i),
    .restart_i    (restart_i),
    .win_done     (win_done),
    .win_hit      (win_hit),
    .gate_block_o (gate_block_o),
    .fault_o      (fault_o)
);

// File: tb/ovp_guard_test.sv
`timescale 1ns/1ps
module ovp_guard_test;

    localparam int BASE = 4;
    localparam int STEP = 2;
    localparam int OFS  = 3;
    localparam int SCAN = 3;
    localparam int PW   = 8;
    localparam int AMAX = 7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       gate = 1'b1;
    logic       cmp = 1'b0;
    logic       off = 1'b0;
    logic       adapt = 1'b0;
    logic [2:0] code = 3'd0;
    logic [2:0] thr = 3'd7;
    logic       latch = 1'b0;
    logic       restart = 1'b0;
    logic       gate_block;
    logic       fault;

    int n_chk = 0;
    int n_fail = 0;

    // Reference model of the requirements
    int m_acc = 0;
    bit m_fault = 0;
    bit m_lat = 0;
    int m_plow = 0;
    bit m_pvld = 0;

    always #2.5 clk = ~clk;

    ovp_guard #(
        .PER_W            (PW),
        .BLANK_BASE_CYC   (BASE),
        .BLANK_STEP_CYC   (STEP),
        .ADAPT_OFFSET_CYC (OFS),
        .SCAN_CYC         (SCAN)
    ) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .gate_i        (gate),
        .cmp_i         (cmp),
        .ovp_off_i     (off),
        .blank_adapt_i (adapt),
        .blank_code_i  (code),
        .trip_level_i  (thr),
        .latch_mode_i  (latch),
        .restart_i     (restart),
        .gate_block_o  (gate_block),
        .fault_o       (fault)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; gate = 1'b1; cmp = 1'b0; restart = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        m_acc = 0; m_fault = 0; m_lat = 0; m_plow = 0; m_pvld = 0;
    endtask

    // One switching cycle: lo low samples (comparator pulse at index hit_at),
    // then hi high samples; checks block after the pulse and fault at the end.
    task automatic sw_cycle(input int hi, input int lo, input int hit_at, input string req);
        int  blen;
        bit  ev;
        if (adapt && m_pvld) blen = (m_plow > OFS) ? m_plow - OFS : 0;
        else                 blen = BASE + STEP * int'(code);
        ev = !off && hit_at >= blen + 1 && hit_at <= blen + SCAN && hit_at < lo;
        for (int j = 0; j < lo; j++) begin
            @(negedge clk);
            if (hit_at >= 0 && j == hit_at + 1)
                check({req, " block after pulse"}, int'(gate_block), int'(ev || m_fault));
            gate = 1'b0;
            cmp  = (j == hit_at);
        end
        // model update (R6/R7/R8, R1 clears)
        if (off) begin
            m_acc = 0;
        end else begin
            if (ev) m_acc = (m_acc == AMAX) ? AMAX : m_acc + 1;
            else    m_acc = (m_acc == 0) ? 0 : m_acc - 1;
            if (!m_fault && m_acc >= int'(thr)) begin
                m_fault = 1;
                m_lat   = latch;
            end
        end
        m_plow = lo;
        m_pvld = 1;
        for (int i = 0; i < hi; i++) begin
            @(negedge clk);
            gate = 1'b1;
            cmp  = 1'b0;
        end
        @(negedge clk);
        check({req, " fault"}, int'(fault), int'(m_fault));
        check({req, " block at cycle end"}, int'(gate_block), int'(m_fault));
    endtask

    task automatic do_restart(input string req);
        @(negedge clk);
        restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
        if (m_fault && !m_lat) begin
            m_fault = 0;
            m_acc   = 0;
        end
        @(negedge clk);
        check({req, " fault after restart"}, int'(fault), int'(m_fault));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        do_reset();
        check("R8 reset fault", int'(fault), 0);
        check("R5 reset block", int'(gate_block), 0);

        // R2 fixed blanking sweep, boundary samples on each side of the scan
        adapt = 1'b0; thr = 3'd7; latch = 1'b0;
        for (int c = 0; c < 8; c++) begin
            int blen;
            code = 3'(c);
            blen = BASE + STEP * c;
            sw_cycle(3, blen + SCAN + 4, blen,            "R2");
            sw_cycle(3, blen + SCAN + 4, blen + 1,        "R2");
            sw_cycle(3, blen + SCAN + 4, blen + SCAN,     "R5");
            sw_cycle(3, blen + SCAN + 4, blen + SCAN + 1, "R5");
        end

        // R3 adaptive blanking from previous low time, including clamp
        adapt = 1'b1;
        for (int k = 0; k < 6; k++) begin
            int lp;
            int blen;
            lp = (k == 0) ? 2 : (k == 1) ? 3 : (k == 2) ? 4 : (k == 3) ? 8 : (k == 4) ? 15 : 20;
            blen = (lp > OFS) ? lp - OFS : 0;
            sw_cycle(3, lp, -1, "R3");
            sw_cycle(3, 30, blen, "R3");
            sw_cycle(3, lp, -1, "R3");
            sw_cycle(3, 30, blen + 1, "R3");
        end

        // R6 window cut short by gate rise: counts as a cycle
        adapt = 1'b0; code = 3'd0;
        sw_cycle(3, 7, 5, "R6");
        sw_cycle(3, 5, 4, "R6");

        // R8/R7/R9 threshold sweep: floor at zero, exact trip count, restart
        for (int t = 1; t < 8; t++) begin
            thr = 3'(t);
            for (int n = 0; n < 8; n++) sw_cycle(2, 10, -1, "R7");
            for (int n = 0; n < t; n++) sw_cycle(2, 10, 5, "R8");
            do_restart("R9");
        end

        // R1 disable clears the accumulator and ignores events
        thr = 3'd7;
        for (int n = 0; n < 3; n++) sw_cycle(2, 10, 5, "R6");
        off = 1'b1;
        for (int n = 0; n < 8; n++) sw_cycle(2, 10, 5, "R1");
        off = 1'b0;
        thr = 3'd2;
        sw_cycle(2, 10, 5, "R1");
        sw_cycle(2, 10, 5, "R8");
        do_restart("R9");

        // R10 latched fault survives restart, cleared by reset
        latch = 1'b1; thr = 3'd2;
        for (int n = 0; n < 8; n++) sw_cycle(2, 10, -1, "R10");
        sw_cycle(2, 30, 5, "R10");
        sw_cycle(2, 30, 5, "R10");
        do_restart("R10");
        check("R10 latched fault held", int'(fault), 1);
        do_reset();
        check("R10 fault after reset", int'(fault), 0);

        // R4 first cycle after reset uses fixed blanking in adaptive mode
        latch = 1'b0; thr = 3'd7; adapt = 1'b1; code = 3'd0;
        sw_cycle(3, 12, 5, "R4");
        sw_cycle(3, 12, 5, "R4");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule